// File: doc/BRIEF.md
# Mantissa Rounding Stage with Four Directed Modes

This block is the combinational rounding step at the end of a floating-point result path. Upstream logic gives it a normalized mantissa that carries two extra low-order bits (guard, then round) and a separate sticky bit. It also gives it the sign of the result and a two-bit rounding-mode selector. The block drops the two extra bits and adds one unit in the last kept place when the selected mode calls for it. It reports whether that increment happened and whether any precision was lost.

From the same mode decode, the block also says where an overflowing result should saturate: to infinity, or to the largest finite magnitude of that sign. The exponent logic uses this answer when it finds an overflow. The block does not renormalize. If an all-ones fraction rounds up, the carry goes into an extra top bit of the output, and the caller must handle the resulting 2.0 value. The mantissa width is a parameter, so the same stage serves every precision.

Top module: `rnd_unit`

## Requirements
- R1: `mantOut` equals `mantIn` shifted right by two, zero-extended by one bit, plus one when `roundedUp` is high.
- R2: When `mantIn[1]` (guard), `mantIn[0]` (round) and `stickyIn` are all zero, `roundedUp` and `inexact` are both low in every mode.
- R3: `inexact` is high whenever guard, round or sticky is high, in every mode and for either sign.
- R4: With `modeIn` = 2'b00 (nearest), the mantissa is incremented only when guard is high and round, sticky or bit 2 of `mantIn` (the kept LSB) is high. An exact half therefore rounds to the even neighbour.
- R5: With `modeIn` = 2'b01 (toward zero), the mantissa is never incremented.
- R6: With `modeIn` = 2'b10 (toward plus infinity), an inexact result is incremented only when `signIn` is 0 (positive). With `modeIn` = 2'b11 (toward minus infinity), it is incremented only when `signIn` is 1 (negative).
- R7: The increment carries through the whole kept field. An all-ones `mantIn` that rounds up gives `mantOut` with only its top bit set.
- R8: `overflowToInf` is 1 for nearest, 0 for toward zero, equal to the inverted sign for toward plus infinity, and equal to the sign for toward minus infinity. It does not depend on the mantissa.
- R9: `roundedUp` is high exactly when the rounding rule of the selected mode applies an increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mantIn | input | MANT_W | Normalized mantissa; bit 1 is guard, bit 0 is round |
| stickyIn | input | 1 | OR of all bits below the round bit |
| signIn | input | 1 | Result sign, 1 = negative |
| modeIn | input | 2 | Rounding mode: 00 nearest, 01 toward zero, 10 toward +inf, 11 toward -inf |
| mantOut | output | MANT_W-1 | Rounded mantissa with carry bit on top |
| roundedUp | output | 1 | Increment was applied |
| inexact | output | 1 | Guard, round or sticky was non-zero |
| overflowToInf | output | 1 | 1 = an overflow saturates to infinity, 0 = to largest finite |

## Verification
Two cases are hard to reach: an exact half under nearest mode, where only the kept LSB decides, and the full-width carry into the top bit. Random mantissas almost never produce either. The stimulus therefore builds them directly. For the ties, guard is set with round and sticky clear, and the kept LSB is toggled. For the carry, an all-ones mantissa is rounded under every incrementing mode and sign. A linear-feedback sequence then sweeps the mode and sign combinations with varied tails.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

  typedef enum logic [1:0] {
    RND_NEAREST = 2'b00,
    RND_ZERO    = 2'b01,
    RND_POS     = 2'b10,
    RND_NEG     = 2'b11
  } rnd_mode_e;

  // Strobes from the mode decode to the mantissa datapath
  typedef struct packed {
    logic inexact;
    logic bumpMant;
    logic satToInf;
  } rnd_strobe_t;

endpackage

// File: rtl/rnd_ctrl.sv
module rnd_ctrl
  import rnd_pkg::*;
(
  input  logic        guardBit,
  input  logic        roundBit,
  input  logic        stickyBit,
  input  logic        keptLsb,
  input  logic        signBit,
  input  logic [1:0]  modeSel,
  output rnd_strobe_t strobes
);

  logic tailNonZero;
  logic nearestUp;

  assign tailNonZero = guardBit | roundBit | stickyBit;
  // above half, or exactly half with odd kept value
  assign nearestUp   = guardBit & (roundBit | stickyBit | keptLsb);

  always_comb begin
    strobes         = '0;
    strobes.inexact = tailNonZero;
    case (rnd_mode_e'(modeSel))
      RND_ZERO: begin
        strobes.bumpMant = 1'b0;
        strobes.satToInf = 1'b0;
      end
      RND_POS: begin
        strobes.bumpMant = tailNonZero & ~signBit;
        strobes.satToInf = ~signBit;
      end
      RND_NEG: begin
        strobes.bumpMant = tailNonZero & signBit;
        strobes.satToInf = signBit;
      end
      default: begin
        strobes.bumpMant = nearestUp;
        strobes.satToInf = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/rnd_dp.sv
module rnd_dp
  import rnd_pkg::*;
#(
  parameter int MANT_W = 27
) (
  input  logic [MANT_W-1:0] mantIn,
  input  rnd_strobe_t       strobes,
  output logic              guardBit,
  output logic              roundBit,
  output logic              keptLsb,
  output logic [MANT_W-2:0] mantOut
);

  localparam int KEEP_W = MANT_W - 2;
  localparam int OUT_W  = KEEP_W + 1;

  logic [KEEP_W-1:0] keptField;

  assign keptField = mantIn[MANT_W-1:2];
  assign guardBit  = mantIn[1];
  assign roundBit  = mantIn[0];
  assign keptLsb   = keptField[0];

  // carry out of the kept field lands in the extra top bit
  assign mantOut = {1'b0, keptField} + OUT_W'(strobes.bumpMant);

endmodule

// File: rtl/rnd_unit.sv
module rnd_unit
  import rnd_pkg::*;
#(
  parameter int MANT_W = 27
) (
  input  logic [MANT_W-1:0] mantIn,
  input  logic              stickyIn,
  input  logic              signIn,
  input  logic [1:0]        modeIn,
  output logic [MANT_W-2:0] mantOut,
  output logic              roundedUp,
  output logic              inexact,
  output logic              overflowToInf
);

  rnd_strobe_t strobes;
  logic guardBit, roundBit, keptLsb;

  rnd_dp #(.MANT_W(MANT_W)) u_dp (
    .mantIn   (mantIn),
    .strobes  (strobes),
    .guardBit (guardBit),
    .roundBit (roundBit),
    .keptLsb  (keptLsb),
    .mantOut  (mantOut)
  );

  rnd_ctrl u_ctrl (
    .guardBit  (guardBit),
    .roundBit  (roundBit),
    .stickyBit (stickyIn),
    .keptLsb   (keptLsb),
    .signBit   (signIn),
    .modeSel   (modeIn),
    .strobes   (strobes)
  );

  assign roundedUp     = strobes.bumpMant;
  assign inexact       = strobes.inexact;
  assign overflowToInf = strobes.satToInf;

endmodule

// File: rtl/rnd_unit_chk.sv
module rnd_unit_chk #(
  parameter int MANT_W = 27
) (
  input logic [MANT_W-1:0] mantIn,
  input logic              stickyIn,
  input logic              signIn,
  input logic [1:0]        modeIn,
  input logic [MANT_W-2:0] mantOut,
  input logic              roundedUp,
  input logic              inexact,
  input logic              overflowToInf
);

  localparam int OUT_W = MANT_W - 1;

  logic [OUT_W-1:0] plainShift;
  logic             tailAny;
  assign plainShift = {1'b0, mantIn[MANT_W-1:2]};
  assign tailAny    = mantIn[1] | mantIn[0] | stickyIn;

  always_comb begin
    assert_mant_value_R1: assert (mantOut == plainShift + OUT_W'(roundedUp))
      else $error("R1 mantissa mismatch");
    if (!tailAny) begin
      assert_exact_quiet_R2: assert (!roundedUp && !inexact)
        else $error("R2 exact input flagged");
    end
    if (tailAny) begin
      assert_inexact_set_R3: assert (inexact)
        else $error("R3 inexact missing");
    end
    if (modeIn == 2'b01) begin
      assert_no_bump_toward_zero_R5: assert (!roundedUp && !overflowToInf)
        else $error("R5 toward zero violated");
    end
    if (modeIn == 2'b10 && signIn) begin
      assert_pos_mode_negative_R6: assert (!roundedUp)
        else $error("R6 +inf mode bumped negative");
    end
    if (modeIn == 2'b11 && !signIn) begin
      assert_neg_mode_positive_R6: assert (!roundedUp)
        else $error("R6 -inf mode bumped positive");
    end
    if (modeIn == 2'b00) begin
      assert_nearest_sat_R8: assert (overflowToInf)
        else $error("R8 nearest must saturate to inf");
    end
  end

endmodule

bind rnd_unit rnd_unit_chk #(.MANT_W(MANT_W)) u_chk (.*);

// File: tb/test_rnd_unit.sv
module test_rnd_unit;

  localparam int MW = 27;
  localparam int OW = MW - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [MW-1:0] mantIn = '0;
  logic          stickyIn = 1'b0;
  logic          signIn = 1'b0;
  logic [1:0]    modeIn = 2'b00;
  logic [OW-1:0] mantOut;
  logic          roundedUp, inexact, overflowToInf;

  rnd_unit #(.MANT_W(MW)) i_rnd_unit (
    .mantIn(mantIn), .stickyIn(stickyIn), .signIn(signIn), .modeIn(modeIn),
    .mantOut(mantOut), .roundedUp(roundedUp), .inexact(inexact),
    .overflowToInf(overflowToInf)
  );

  typedef struct {
    logic [OW-1:0] mant;
    logic          up;
    logic          nx;
    logic          inf;
    string         tag;
  } exp_t;

  exp_t expQ[$];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  task automatic check1(input string tag, input string what,
                        input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // independent reference model built from the requirement text
  task automatic drive(input logic [MW-1:0] m, input logic s, input logic sg,
                       input logic [1:0] md, input string tag);
    exp_t e;
    logic aboveHalf, exactHalf, anyTail, bump;
    aboveHalf = m[1] && (m[0] || s);
    exactHalf = m[1] && !m[0] && !s;
    anyTail   = (m[1:0] != 2'b00) || s;
    case (md)
      2'b00: bump = aboveHalf || (exactHalf && m[2]);
      2'b01: bump = 1'b0;
      2'b10: bump = anyTail && (sg == 1'b0);
      default: bump = anyTail && (sg == 1'b1);
    endcase
    e.mant = OW'(m / 4) + (bump ? OW'(1) : OW'(0));
    e.up   = bump;
    e.nx   = anyTail;
    e.inf  = (md == 2'b00) ? 1'b1 : (md == 2'b01) ? 1'b0 :
             (md == 2'b10) ? !sg : sg;
    e.tag  = tag;
    @(negedge clk);
    mantIn = m; stickyIn = s; signIn = sg; modeIn = md;
    expQ.push_back(e);
  endtask

  // monitor: compare at the following rising edge
  always @(posedge clk) begin
    if (rst_n && expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      check1(e.tag, "mantOut", longint'(mantOut), longint'(e.mant));
      check1(e.tag, "roundedUp R9", longint'(roundedUp), longint'(e.up));
      check1(e.tag, "inexact R3", longint'(inexact), longint'(e.nx));
      check1(e.tag, "overflowToInf R8", longint'(overflowToInf), longint'(e.inf));
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    logic [MW-1:0] allOnes;
    logic [31:0]   lfsr;
    allOnes = '1;
    lfsr = 32'hACE1_2357;
    repeat (3) @(posedge clk);
    #1;
    // reset state: zero inputs, nearest mode
    check1("R2", "reset mantOut", longint'(mantOut), 0);
    check1("R2", "reset roundedUp", longint'(roundedUp), 0);
    check1("R2", "reset inexact", longint'(inexact), 0);
    check1("R8", "reset overflowToInf", longint'(overflowToInf), 1);
    rst_n = 1'b1;

    // R1 R2: exact inputs in every mode/sign
    for (int md = 0; md < 4; md++) begin
      drive(27'h4A5_B3C0 & ~27'h3, 1'b0, md[0], 2'(md), "R2");
      drive(27'h123_4568, 1'b0, !md[0], 2'(md), "R1");
    end
    // R4: nearest ties and above/below half
    drive(27'h000_0006, 1'b0, 1'b0, 2'b00, "R4");  // tie, odd -> up
    drive(27'h000_0002, 1'b0, 1'b0, 2'b00, "R4");  // tie, even -> stay
    drive(27'h000_0002, 1'b1, 1'b1, 2'b00, "R4");  // above half by sticky
    drive(27'h000_0003, 1'b0, 1'b0, 2'b00, "R4");  // above half by round
    drive(27'h000_0005, 1'b1, 1'b0, 2'b00, "R4");  // below half
    // R5: toward zero with full tail
    drive(27'h0FF_FFFF, 1'b1, 1'b0, 2'b01, "R5");
    drive(27'h0FF_FFFF, 1'b1, 1'b1, 2'b01, "R5");
    // R6: directed modes, both signs
    drive(27'h000_1001, 1'b0, 1'b0, 2'b10, "R6");
    drive(27'h000_1001, 1'b0, 1'b1, 2'b10, "R6");
    drive(27'h000_1000, 1'b1, 1'b1, 2'b11, "R6");
    drive(27'h000_1000, 1'b1, 1'b0, 2'b11, "R6");
    // R7: full carry into top bit
    drive(allOnes, 1'b0, 1'b0, 2'b00, "R7");
    drive(allOnes, 1'b1, 1'b0, 2'b10, "R7");
    drive(allOnes, 1'b0, 1'b1, 2'b11, "R7");
    drive(allOnes, 1'b1, 1'b1, 2'b01, "R7");
    // R8: saturation choice independent of mantissa
    for (int k = 0; k < 8; k++)
      drive(27'h0, 1'b0, k[0], k[2:1], "R8");
    // sweep
    for (int n = 0; n < 200; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      drive(MW'(lfsr ^ (lfsr >> 7)), lfsr[3], lfsr[9], lfsr[5:4], "R9");
    end
    @(negedge clk);
    @(negedge clk);
    done = 1;
    finish_run();
  end

endmodule